// File: doc/BRIEF.md
# Serial Converter Target Controller

This block is the digital front end of a 16-bit unipolar sampling converter that answers on a two-wire (I2C) bus as a target. It cleans up the incoming clock and data lines, detects START, repeated START and STOP conditions, compares the 7-bit address against a fixed upper part plus four board strap pins, and when addressed it acquires and converts a sample. While the converter core works, the block holds the bus clock low. When the result arrives, it streams the result out MSB first. It keeps doing this frame after frame for as long as the controller keeps acknowledging.

The converter core sits behind a plain request/done handshake that returns a 16-bit word. The block drives the core's track/hold control and a reference power enable. The R/W bit of the address byte chooses the reference policy. With R/W at 1 the reference stays on for the whole transfer. With R/W at 0 it is powered only while a sample is acquired or converted. The bus is open-drain, so the block reports "pull low" requests for SCL and SDA and never drives a line high.

Top module: `i2c_adc_target`

## Requirements
- R1: After reset, scl_low, sda_low, conv_req, track_hold and ref_on are all 0.
- R2: The address is the 7-bit value {ADDR_HI = 3'b011, addr_strap[3:0]}, sent MSB first and followed by the R/W bit. On a match the target pulls SDA low (ACK) during the 9th clock. On a mismatch SDA stays released (NACK), and no conversion or SDA drive happens until the next START.
- R3: After a matching address, track_hold is 1 from the falling SCL edge of the 7th clock to the falling edge of the 9th, so it covers exactly the 8th and 9th clocks. conv_req only rises directly after such a window.
- R4: From the falling edge of the 9th clock, conv_req is 1 and SCL is held low (scl_low = 1) until conv_done arrives. Both are released in the cycle after conv_done, and track_hold stays 0 during the hold.
- R5: A frame is 18 clocks: result bits 15..8, a controller acknowledge slot, result bits 7..0, and a second acknowledge slot. The target releases SDA in both slots. Data bits follow the captured word exactly, including all-zero and all-one words.
- R6: When the controller ACKs (SDA low) the slot after the low byte, track_hold is 1 during clocks 17 and 18, and a new conversion with SCL held low starts at the falling edge of clock 18.
- R7: A controller NACK (SDA high) in either acknowledge slot ends the stream. No further conversion starts, and SDA stays released for the rest of the transfer.
- R8: ref_on is 1 during acquisition and conversion. After an address with R/W = 1, it also stays 1 while data is shifted, until the transfer ends (STOP, NACK or a new START). With R/W = 0 it is 0 while data is shifted.
- R9: A START or STOP in the middle of a byte aborts the transfer. A repeated START begins a new address phase, and a STOP returns to idle with every output released.
- R10: Pulses on SCL or SDA shorter than FILT_FS (7) clock cycles are ignored. After a master-code byte 8'b0000_1xxx, which is NACKed, the limit drops to FILT_HS (3) cycles until the next STOP.
- R11: SDA driven by the target changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| addr_strap | input | 4 | Strap pins giving the low four address bits |
| conv_done | input | 1 | One-cycle pulse from the converter core: result valid |
| conv_data | input | 16 | Conversion result, valid with conv_done |
| scl_low | output | 1 | Pull SCL low (clock stretching during conversion) |
| sda_low | output | 1 | Pull SDA low (ACK or a 0 data bit) |
| conv_req | output | 1 | Conversion request, held until conv_done |
| track_hold | output | 1 | 1 = track the input, 0 = hold |
| ref_on | output | 1 | Reference power enable |

## Verification
The main path is tried with several patterns: a single frame, back-to-back continuous frames, random strap values with random address choices, and an R/W mix. Together these separate a correct address compare, correct reference policy and correct sample ordering from off-by-one errors in the frame count. Result words include all-zero and all-one values and hashed values, so a bit-order or byte-order fault cannot hide. Directed runs add a wrong address, a NACK after the high byte, a repeated START and a STOP in the middle of the address, short glitches on both lines, and a master-code entry into the faster mode with tighter glitches. These separate correct abort and filter behaviour from a design that happens to work only on clean traffic.

// File: rtl/adcif_pkg.sv
package adcif_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_CONV,
    ST_DATA,
    ST_MACK,
    ST_SKIP
  } xfer_st_t;
endpackage

// File: rtl/adcif_filter.sv
module adcif_filter #(
  parameter int FILT_FS = 7,
  parameter int FILT_HS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic hs,
  output logic clean
);
  localparam int CW = (FILT_FS > 2) ? $clog2(FILT_FS) : 1;

  logic          s1_q, s2_q;
  logic          out_q, out_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim;

  assign lim = hs ? CW'(FILT_HS - 1) : CW'(FILT_FS - 1);

  always_comb begin
    out_d = out_q;
    cnt_d = '0;
    if (s2_q != out_q) begin
      if (cnt_q >= lim) begin
        out_d = s2_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
      out_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      s1_q  <= raw;
      s2_q  <= s1_q;
      out_q <= out_d;
      cnt_q <= cnt_d;
    end
  end

  assign clean = out_q;

  // R10: the cleaned line only moves after at least two agreeing samples
  assert_filter_agree_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clean != $past(clean)) |-> ($past(s2_q) == clean) && ($past(s2_q, 2) == clean));
endmodule

// File: rtl/adcif_events.sv
module adcif_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
  assign start_c  = scl & scl_q & sda_q & ~sda;
  assign stop_c   = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/adcif_xfer.sv
module adcif_xfer
  import adcif_pkg::*;
#(
  parameter int                 STRAP_W = 4,
  parameter logic [6-STRAP_W:0] ADDR_HI = 3'b011,
  parameter int                 RES_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_f,
  input  logic               sda_f,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_c,
  input  logic               stop_c,
  input  logic [STRAP_W-1:0] strap,
  input  logic               conv_done,
  input  logic [RES_W-1:0]   conv_data,
  output logic               scl_low,
  output logic               sda_low,
  output logic               conv_req,
  output logic               track_hold,
  output logic               ref_on,
  output logic               hs_mode
);
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;
  localparam int NBYTES = RES_W / BYTE_W;
  localparam int BC_W   = $clog2(BYTE_W + 1);
  localparam int BI_W   = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [BC_W-1:0] BC_LASTA = BC_W'(ADDR_W - 1);
  localparam logic [BC_W-1:0] BC_ADDR  = BC_W'(ADDR_W);
  localparam logic [BC_W-1:0] BC_BYTE  = BC_W'(BYTE_W);
  localparam logic [BC_W-1:0] BC_LAST  = BC_W'(BYTE_W - 1);
  localparam logic [BC_W-1:0] BC_TRK   = BC_W'(BYTE_W - 2);
  localparam logic [BI_W-1:0] BI_LAST  = BI_W'(NBYTES - 1);
  localparam logic [4:0]      MCODE    = 5'b00001;

  xfer_st_t             st_q, st_d;
  logic [BC_W-1:0]      bit_q, bit_d;
  logic [BI_W-1:0]      byte_q, byte_d;
  logic [BYTE_W-1:0]    sh_q, sh_d;
  logic [RES_W-1:0]     tx_q, tx_d;
  logic                 match_q, match_d;
  logic                 ack_q, ack_d;
  logic                 track_q, track_d;
  logic                 keep_q, keep_d;
  logic                 hs_q, hs_d;

  always_comb begin
    st_d    = st_q;
    bit_d   = bit_q;
    byte_d  = byte_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    match_d = match_q;
    ack_d   = ack_q;
    track_d = track_q;
    keep_d  = keep_q;
    hs_d    = hs_q;
    if (stop_c) begin
      st_d    = ST_IDLE;
      track_d = 1'b0;
      keep_d  = 1'b0;
      hs_d    = 1'b0;
    end else if (start_c) begin
      st_d    = ST_ADDR;
      bit_d   = '0;
      match_d = 1'b0;
      track_d = 1'b0;
      keep_d  = 1'b0;
    end else begin
      case (st_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_f};
            bit_d = bit_q + 1'b1;
            if (bit_q == BC_LASTA) begin
              match_d = ({sh_q[ADDR_W-2:0], sda_f} == {ADDR_HI, strap});
            end
          end else if (scl_fall) begin
            if (bit_q == BC_ADDR && match_q) begin
              track_d = 1'b1;
            end
            if (bit_q == BC_BYTE) begin
              if (match_q) begin
                st_d   = ST_AACK;
                keep_d = sh_q[0];
              end else begin
                st_d = ST_SKIP;
                if (sh_q[BYTE_W-1:3] == MCODE) begin
                  hs_d = 1'b1;
                end
              end
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            st_d    = ST_CONV;
            track_d = 1'b0;
          end
        end
        ST_CONV: begin
          if (conv_done) begin
            tx_d   = conv_data;
            st_d   = ST_DATA;
            bit_d  = '0;
            byte_d = '0;
          end
        end
        ST_DATA: begin
          if (scl_fall) begin
            tx_d  = {tx_q[RES_W-2:0], 1'b0};
            bit_d = bit_q + 1'b1;
            if (bit_q == BC_TRK && byte_q == BI_LAST) begin
              track_d = 1'b1;
            end
            if (bit_q == BC_LAST) begin
              st_d = ST_MACK;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            ack_d = ~sda_f;
          end else if (scl_fall) begin
            if (!ack_q) begin
              st_d    = ST_IDLE;
              track_d = 1'b0;
              keep_d  = 1'b0;
            end else if (byte_q == BI_LAST) begin
              st_d    = ST_CONV;
              track_d = 1'b0;
            end else begin
              st_d   = ST_DATA;
              byte_d = byte_q + 1'b1;
              bit_d  = '0;
            end
          end
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      bit_q   <= '0;
      byte_q  <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      match_q <= 1'b0;
      ack_q   <= 1'b0;
      track_q <= 1'b0;
      keep_q  <= 1'b0;
      hs_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      bit_q   <= bit_d;
      byte_q  <= byte_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      match_q <= match_d;
      ack_q   <= ack_d;
      track_q <= track_d;
      keep_q  <= keep_d;
      hs_q    <= hs_d;
    end
  end

  assign scl_low    = (st_q == ST_CONV);
  assign conv_req   = (st_q == ST_CONV);
  assign sda_low    = (st_q == ST_AACK) | ((st_q == ST_DATA) & ~tx_q[RES_W-1]);
  assign track_hold = track_q;
  assign ref_on     = keep_q | track_q | conv_req;
  assign hs_mode    = hs_q;

  // R11: data line only moves while the clock is low
  assert_sda_moves_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_low != $past(sda_low)) |-> !scl_f);

  // R4: no tracking while the clock is stretched
  assert_hold_in_stretch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    scl_low |-> !track_hold);

  // R3: each conversion request follows an acquisition window
  assert_acq_before_conv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_req) |-> $past(track_hold));

  // R4: request withdrawn only after the core answered
  assert_release_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_req) |-> $past(conv_done));

  // R10: fast filter mode ends at STOP
  assert_hs_ends_at_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !hs_mode);
endmodule

// File: rtl/i2c_adc_target.sv
module i2c_adc_target #(
  parameter logic [2:0] ADDR_HI = 3'b011,
  parameter int         FILT_FS = 7,
  parameter int         FILT_HS = 3,
  parameter int         RES_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [3:0]       addr_strap,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  output logic             scl_low,
  output logic             sda_low,
  output logic             conv_req,
  output logic             track_hold,
  output logic             ref_on
);
  localparam int NLINES = 2;

  logic              rst_meta, rst_sync_n;
  logic [NLINES-1:0] raw_v, clean_v;
  logic              hs_mode;
  logic              scl_rise, scl_fall, start_c, stop_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign raw_v = {sda_in, scl_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    adcif_filter #(
      .FILT_FS(FILT_FS),
      .FILT_HS(FILT_HS)
    ) u_filt (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .raw  (raw_v[g]),
      .hs   (hs_mode),
      .clean(clean_v[g])
    );
  end

  adcif_events u_events (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .scl     (clean_v[0]),
    .sda     (clean_v[1]),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_c (start_c),
    .stop_c  (stop_c)
  );

  adcif_xfer #(
    .STRAP_W(4),
    .ADDR_HI(ADDR_HI),
    .RES_W  (RES_W)
  ) u_xfer (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_f     (clean_v[0]),
    .sda_f     (clean_v[1]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_c   (start_c),
    .stop_c    (stop_c),
    .strap     (addr_strap),
    .conv_done (conv_done),
    .conv_data (conv_data),
    .scl_low   (scl_low),
    .sda_low   (sda_low),
    .conv_req  (conv_req),
    .track_hold(track_hold),
    .ref_on    (ref_on),
    .hs_mode   (hs_mode)
  );
endmodule

// File: tb/test_i2c_adc_target.sv
module test_i2c_adc_target;
  localparam int Q_FS     = 25;
  localparam int Q_HS     = 10;
  localparam int CONV_LAT = 60;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, scl_m, sda_m, conv_done;
  logic [3:0]  strap;
  logic [15:0] conv_data;
  logic        scl_low, sda_low, conv_req, track_hold, ref_on;
  logic        scl_bus, sda_bus;
  int          total, bad, q, glen, conv_cnt;
  int unsigned base;

  assign scl_bus = scl_m & ~scl_low;
  assign sda_bus = sda_m & ~sda_low;

  i2c_adc_target i_i2c_adc_target (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
    .addr_strap(strap), .conv_done(conv_done), .conv_data(conv_data),
    .scl_low(scl_low), .sda_low(sda_low), .conv_req(conv_req),
    .track_hold(track_hold), .ref_on(ref_on));

  function automatic logic [15:0] sample_of(int k);
    if (k % 5 == 1) return 16'h0000;
    if (k % 5 == 2) return 16'hFFFF;
    return 16'((base + 32'(k) * 32'd40503) ^ 32'h5a3c);
  endfunction

  function automatic logic addr_hit(logic [6:0] a, logic [3:0] s);
    return a == {3'b011, s};
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl();
    while (!scl_bus) @(negedge clk);
  endtask

  // converter core model
  initial begin
    conv_done = 1'b0; conv_data = '0; conv_cnt = 0;
    forever begin
      @(negedge clk);
      if (conv_req && !conv_done) begin
        wt(CONV_LAT);
        conv_data = sample_of(conv_cnt);
        conv_cnt++;
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
      end
    end
  end

  task automatic bit_io(input logic b, output logic r);
    logic r_end;
    sda_m = b;
    if (glen > 0) begin
      wt(3); scl_m = 1'b1; wt(glen); scl_m = 1'b0; wt(q - 3 - glen);
    end else wt(q);
    scl_m = 1'b1;
    wait_scl();
    wt(q);
    r = sda_bus;
    if (glen > 0 && b) begin
      sda_m = 1'b0; wt(glen); sda_m = 1'b1; wt(q - glen);
    end else wt(q);
    r_end = sda_bus;
    if (glen == 0) chk("R11 SDA stable while SCL high", r_end, r);
    scl_m = 1'b0;
    wt(q);
  endtask

  task automatic do_start();
    sda_m = 1'b1; wt(q); scl_m = 1'b1; wait_scl(); wt(q);
    sda_m = 1'b0; wt(q); scl_m = 1'b0; wt(q);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wt(q); scl_m = 1'b1; wait_scl(); wt(q);
    sda_m = 1'b1; wt(q);
  endtask

  task automatic addr_phase(input logic [6:0] a, input logic rw, input logic em,
                            output logic ackd);
    logic [7:0] by;
    logic r;
    by = {a, rw};
    for (int i = 7; i >= 0; i--) begin
      bit_io(by[i], r);
      if (i == 2) chk("R3 no tracking before 7th fall", track_hold, 1'b0);
      if (i == 1) chk("R3 tracking in 8th clock", track_hold, em);
      if (i == 0) chk("R3 tracking in 9th clock", track_hold, em);
    end
    bit_io(1'b1, r);
    ackd = ~r;
    chk("R2 address ACK", ackd, em);
    if (em) begin
      chk("R4 SCL stretched", scl_low, 1'b1);
      chk("R4 conversion requested", conv_req, 1'b1);
      chk("R4 hold during conversion", track_hold, 1'b0);
    end
  endtask

  task automatic read_frames(input int nfr, input logic rw, input int k0);
    logic [15:0] exp;
    logic [7:0]  got;
    logic        r, last;
    for (int f = 0; f < nfr; f++) begin
      exp = sample_of(k0 + f);
      for (int b = 0; b < 2; b++) begin
        got = '0;
        for (int i = 7; i >= 0; i--) begin
          bit_io(1'b1, r);
          got[i] = r;
          if (b == 0 && i == 4) chk("R8 reference policy while shifting", ref_on, rw);
          if (b == 1 && i == 2) chk("R6 no tracking before clock 17", track_hold, 1'b0);
          if (b == 1 && i == 1) chk("R6 tracking in clock 17", track_hold, 1'b1);
        end
        chk("R5 result byte", got, (b == 0) ? exp[15:8] : exp[7:0]);
        last = (f == nfr - 1) && (b == 1);
        bit_io(last, r);
        if (b == 1 && !last) begin
          chk("R6 next conversion requested", conv_req, 1'b1);
          chk("R6 SCL stretched again", scl_low, 1'b1);
        end
        if (last) begin
          chk("R7 no conversion after NACK", conv_req, 1'b0);
          chk("R7 tracking off after NACK", track_hold, 1'b0);
        end
      end
    end
  endtask

  task automatic txn(input logic [6:0] a, input logic rw, input int nfr);
    logic ackd, em, r, all_hi;
    int   k0;
    k0 = conv_cnt;
    em = addr_hit(a, strap);
    do_start();
    addr_phase(a, rw, em, ackd);
    if (em) read_frames(nfr, rw, k0);
    else begin
      all_hi = 1'b1;
      for (int i = 0; i < 9; i++) begin
        bit_io(1'b1, r);
        if (!r || conv_req) all_hi = 1'b0;
      end
      chk("R2 mismatch ignores traffic", all_hi, 1'b1);
      chk("R2 mismatch starts no conversion", conv_cnt, k0);
    end
    do_stop();
    wt(q);
    chk("R8 reference off after STOP", ref_on, 1'b0);
    chk("R9 SCL released after STOP", scl_low, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic       ackd, r, all_hi;
    logic [7:0] mc;
    int         k0;
    total = 0; bad = 0; q = Q_FS; glen = 0;
    scl_m = 1'b1; sda_m = 1'b1; strap = 4'h5; rst_n = 1'b0;
    void'($urandom(32'h1d2c));
    base = $urandom;
    wt(6); rst_n = 1'b1; wt(6);

    chk("R1 scl_low after reset", scl_low, 1'b0);
    chk("R1 sda_low after reset", sda_low, 1'b0);
    chk("R1 conv_req after reset", conv_req, 1'b0);
    chk("R1 track_hold after reset", track_hold, 1'b0);
    chk("R1 ref_on after reset", ref_on, 1'b0);

    txn(7'b011_0101, 1'b0, 1);   // single frame, reference cycled
    txn(7'b011_0101, 1'b1, 3);   // continuous frames, reference kept
    txn(7'b011_0110, 1'b0, 1);   // wrong address

    // R7: NACK after high byte
    k0 = conv_cnt;
    do_start();
    addr_phase(7'b011_0101, 1'b0, 1'b1, ackd);
    for (int i = 0; i < 8; i++) bit_io(1'b1, r);
    bit_io(1'b1, r);
    all_hi = 1'b1;
    for (int i = 0; i < 9; i++) begin
      bit_io(1'b1, r);
      if (!r || conv_req) all_hi = 1'b0;
    end
    chk("R7 stream ended after high-byte NACK", all_hi, 1'b1);
    chk("R7 only one conversion", conv_cnt, k0 + 1);
    do_stop();

    // R9: repeated START mid address
    do_start();
    for (int i = 0; i < 4; i++) bit_io(1'b0, r);
    k0 = conv_cnt;
    do_start();
    addr_phase(7'b011_0101, 1'b0, 1'b1, ackd);
    read_frames(1, 1'b0, k0);
    do_stop();
    // R9: STOP mid address
    do_start();
    for (int i = 0; i < 3; i++) bit_io(1'b0, r);
    do_stop();
    wt(q);
    chk("R9 idle after mid-byte STOP", conv_req, 1'b0);
    chk("R9 SDA released after mid-byte STOP", sda_bus, 1'b1);

    // R10: short glitches in fast mode
    glen = 5;
    txn(7'b011_0101, 1'b0, 1);
    glen = 0;

    // R10: master code, then fast mode with shorter glitches
    do_start();
    mc = 8'b0000_1010;
    for (int i = 7; i >= 0; i--) bit_io(mc[i], r);
    bit_io(1'b1, r);
    chk("R10 master code NACKed", r, 1'b1);
    q = Q_HS; glen = 2;
    txn(7'b011_0101, 1'b1, 2);
    q = Q_FS; glen = 0;

    // constrained random transfers
    for (int n = 0; n < 5; n++) begin
      logic [6:0] a;
      strap = 4'($urandom);
      a = ($urandom % 4 == 0) ? 7'($urandom) : {3'b011, strap};
      txn(a, 1'($urandom), 1 + int'($urandom % 3));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule